// File: doc/BRIEF.md
# SD Command Line Engine

This block runs a single SD-bus command exchange on the CMD wire. Software programs a control word, a response timeout, an SD clock divider and then the 32-bit argument; the argument write launches the command. The engine assembles the 48-bit command frame with its CRC7, shifts it out on a divided SD clock and, when asked, listens for a 48-bit or 136-bit reply. It checks the reply, stores it in four 32-bit response words and posts a status code that software clears by writing the status register.

The sequencer has five states. ST_IDLE waits for a launch and moves to ST_SEND. ST_SEND drives one frame bit per SD clock fall. After the 48th bit it releases the line on the next fall. It goes back to ST_IDLE when no reply is expected, otherwise to ST_WAIT. ST_WAIT samples the line on each SD clock rise. A low bit moves it to ST_RECV. A count of high samples that reaches the timeout returns it to ST_IDLE with a timeout code. ST_RECV collects the reply bits. After the last bit it returns to ST_IDLE, or it moves to ST_BUSY when a busy wait is requested and the reply checked clean. ST_BUSY returns to ST_IDLE when the busy input drops or when the timeout count runs out. A soft reset forces ST_IDLE from any state.

Register offsets (4-bit word address): 0 control word, 1 argument, 2 timeout, 3 divider, 4 soft reset, 5 status, 8 to 11 response words 0 to 3. Other offsets read zero.

Top module: `sdcmd_engine`

## Requirements
- R1: Writing offset 1 while idle sends the frame 0, 1, index (control bits 13:8), argument, CRC7 (x^7+x^3+1 over the preceding 40 bits), 1. Bits go out MSB first, and `cmd_out` changes only when `sd_clk` falls.
- R2: `sd_clk` has a period of (divider + 1) reference cycles. A divider value of 0 acts as 1.
- R3: With response kind 0 (control bits 1:0 equal to 0 or 3), status becomes 0x01 once the line is released after the stop bit.
- R4: With response kind 1, a 48-bit reply is sampled on `sd_clk` rises. Its 32 payload bits go to response word 0, words 1 to 3 read zero, and a clean check gives status 0x01.
- R5: With control bit 3 set, a CRC7 mismatch in the reply gives status 0x0A. With bit 3 clear, a bad CRC is ignored and status is 0x01.
- R6: With control bit 4 set, a 48-bit reply whose index field differs from the sent index gives status 0x12. With bit 4 clear, the index is ignored.
- R7: With response kind 2, the 128 bits after the 8 header bits fill response words 0 (most significant) to 3. The CRC7 covers the 120 bits after the header.
- R8: In ST_WAIT, when the line has stayed high for the programmed number of SD clock rises (offset 2), status becomes 0x06. It stays 0 one rise earlier.
- R9: With control bit 2 set, completion after a clean reply is held while `busy_in` is 1. Status becomes 0x01 after `busy_in` drops.
- R10: Status reads 0 after reset, and any write to offset 5 clears it.
- R11: Writing 1 to offset 4 holds the engine idle, reads back 1 and blocks launches. Offset 4 reads 1 while a command is in progress and 0 once released and idle.
- R12: `cmd_oe` is high only while frame bits are being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sd_clk | output | 1 | Divided SD bus clock |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |
| busy_in | input | 1 | Card busy indication, 1 while busy |

## Verification
The hardest case to reach is the exact timeout boundary of R8. The count runs in SD clock rises from the release of the line, so the bench follows `sd_clk` edges after the stop bit. It reads status after the fourth rise, expecting zero, and after the fifth, expecting 0x06. The busy hold of R9 requires the bench, acting as the card, to keep `busy_in` high past a clean reply and confirm that no status has posted. Corrupted CRC and index fields are produced by the bench card model, both with the checks enabled and with them disabled.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_BUSY
    } eng_state_t;

    localparam logic [3:0] RA_CTRL = 4'd0;
    localparam logic [3:0] RA_ARG  = 4'd1;
    localparam logic [3:0] RA_TMO  = 4'd2;
    localparam logic [3:0] RA_DIV  = 4'd3;
    localparam logic [3:0] RA_SRST = 4'd4;
    localparam logic [3:0] RA_STAT = 4'd5;
    localparam logic [3:0] RA_RSP0 = 4'd8;
    localparam logic [3:0] RA_RSP1 = 4'd9;
    localparam logic [3:0] RA_RSP2 = 4'd10;
    localparam logic [3:0] RA_RSP3 = 4'd11;

    localparam logic [4:0] STAT_OK      = 5'b00001;
    localparam logic [4:0] STAT_TIMEOUT = 5'b00110;

    // one step of the x^7 + x^3 + 1 register
    function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

    // CRC7 over the low n bits of d, highest of them first
    function automatic logic [6:0] crc7_span(input logic [119:0] d, input int n);
        logic [6:0] c;
        c = '0;
        for (int i = 119; i >= 0; i--) begin
            if (i < n) c = crc7_next(c, d[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             sd_clk,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim     = (div == '0) ? DIV_W'(1) : div;
        rise_ev = !hold && (cnt >= lim);
        fall_ev = !hold && (cnt == (lim >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sd_clk <= 1'b0;
        end else if (hold) begin
            cnt    <= '0;
            sd_clk <= 1'b0;
        end else begin
            if (rise_ev) begin
                cnt    <= '0;
                sd_clk <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (fall_ev) sd_clk <= 1'b0;
        end
    end

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int TMO_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              launch,
    input  logic [5:0]        cmd_index,
    input  logic [1:0]        rsp_kind,
    input  logic              busy_req,
    input  logic              crc_req,
    input  logic              idx_req,
    input  logic [31:0]       arg,
    input  logic [TMO_W-1:0]  tmo,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              cmd_in,
    input  logic              busy_in,
    input  logic              clr_status,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic [4:0]        status,
    output logic [3:0][31:0]  resp,
    output logic              active
);
    eng_state_t state, nxt;

    logic [5:0]       cur_idx;
    logic [1:0]       cur_kind;
    logic             cur_busy, cur_crc, cur_ichk;
    logic [47:0]      txsr;
    logic [126:0]     rxsr;
    logic [127:0]     rx_next;
    logic [7:0]       nbits;
    logic [7:0]       rx_last;
    logic [TMO_W-1:0] tcnt;
    logic             rsp_none, rsp_long, tmo_hit, crc_bad, idx_bad, rx_end, tx_end;
    logic [6:0]       crc_calc;
    logic [39:0]      frame_head;

    always_comb begin
        rsp_none   = (cur_kind == 2'd0) || (cur_kind == 2'd3);
        rsp_long   = (cur_kind == 2'd2);
        rx_last    = rsp_long ? 8'(LONG_BITS - 1) : 8'(FRAME_BITS - 1);
        rx_next    = {rxsr, cmd_in};
        tmo_hit    = ({1'b0, tcnt} + 1'b1) >= {1'b0, tmo};
        crc_calc   = rsp_long ? crc7_span(rx_next[127:8], 120)
                              : crc7_span({80'b0, rx_next[47:8]}, 40);
        crc_bad    = cur_crc && (crc_calc != rx_next[7:1]);
        idx_bad    = cur_ichk && !rsp_long && (rx_next[45:40] != cur_idx);
        tx_end     = fall_ev && (nbits == 8'(FRAME_BITS));
        rx_end     = rise_ev && (nbits == rx_last);
        frame_head = {2'b01, cmd_index, arg};
        active     = (state != ST_IDLE);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch) nxt = ST_SEND;
            ST_SEND: if (tx_end) nxt = rsp_none ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (rise_ev) begin
                if (!cmd_in)      nxt = ST_RECV;
                else if (tmo_hit) nxt = ST_IDLE;
            end
            ST_RECV: if (rx_end) nxt = (crc_bad || idx_bad || !cur_busy) ? ST_IDLE : ST_BUSY;
            ST_BUSY: if (rise_ev && (!busy_in || tmo_hit)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (srst) state <= ST_IDLE;
        else           state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_out <= 1'b1; cmd_oe <= 1'b0; status <= '0; resp <= '0;
            txsr <= '0; rxsr <= '0; nbits <= '0; tcnt <= '0;
            cur_idx <= '0; cur_kind <= '0; cur_busy <= 1'b0; cur_crc <= 1'b0; cur_ichk <= 1'b0;
        end else if (srst) begin
            cmd_out <= 1'b1; cmd_oe <= 1'b0; status <= '0; resp <= '0;
            txsr <= '0; rxsr <= '0; nbits <= '0; tcnt <= '0;
            cur_idx <= '0; cur_kind <= '0; cur_busy <= 1'b0; cur_crc <= 1'b0; cur_ichk <= 1'b0;
        end else begin
            if (clr_status) status <= '0;
            unique case (state)
                ST_IDLE: if (launch) begin
                    cur_idx  <= cmd_index;
                    cur_kind <= rsp_kind;
                    cur_busy <= busy_req;
                    cur_crc  <= crc_req;
                    cur_ichk <= idx_req;
                    txsr     <= {frame_head, crc7_span({80'b0, frame_head}, 40), 1'b1};
                    nbits    <= '0;
                end
                ST_SEND: if (fall_ev) begin
                    if (tx_end) begin
                        cmd_oe  <= 1'b0;
                        cmd_out <= 1'b1;
                        tcnt    <= '0;
                        nbits   <= '0;
                        if (rsp_none) status <= STAT_OK;
                    end else begin
                        cmd_oe  <= 1'b1;
                        cmd_out <= txsr[47];
                        txsr    <= {txsr[46:0], 1'b0};
                        nbits   <= nbits + 1'b1;
                    end
                end
                ST_WAIT: if (rise_ev) begin
                    if (!cmd_in) begin
                        rxsr  <= rx_next[126:0];
                        nbits <= 8'd1;
                    end else if (tmo_hit) begin
                        status <= STAT_TIMEOUT;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_RECV: if (rise_ev) begin
                    rxsr  <= rx_next[126:0];
                    nbits <= nbits + 1'b1;
                    if (rx_end) begin
                        tcnt <= '0;
                        if (rsp_long) resp <= {rx_next[31:0], rx_next[63:32], rx_next[95:64], rx_next[127:96]};
                        else          resp <= {96'b0, rx_next[39:8]};
                        if (crc_bad || idx_bad) status <= {idx_bad, crc_bad, 1'b0, 1'b1, 1'b0};
                        else if (!cur_busy)     status <= STAT_OK;
                    end
                end
                ST_BUSY: if (rise_ev) begin
                    if (!busy_in)     status <= STAT_OK;
                    else if (tmo_hit) status <= STAT_TIMEOUT;
                    else              tcnt <= tcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R12: the line is driven only while frame bits go out
    a_r12_drive_only_sending: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> (state == ST_SEND));

    // R3: a fresh status code only appears as the engine returns to idle
    a_r3_status_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        ((status != 5'b0) && ($past(status) == 5'b0)) |-> (state == ST_IDLE));

    // R8: a timeout code carries no check-failure cause
    a_r8_timeout_alone: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (status[4:3] == 2'b00 && status[1] && !status[0]));

    // R5: an error code never carries the completion bit
    a_r5_error_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> !status[0]);

    // R11: soft reset leaves the engine idle with the line released
    a_r11_srst_idles: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state == ST_IDLE && !cmd_oe));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int TMO_W     = 24,
    parameter int DIV_RESET = 54
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sd_clk,
    output logic        cmd_out,
    output logic        cmd_oe,
    input  logic        cmd_in,
    input  logic        busy_in
);
    logic [13:0]       ctrl_q;
    logic [31:0]       arg_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [DIV_W-1:0]  div_q;
    logic              srst_q;
    logic              rise_ev, fall_ev, launch, clr_status, eng_active;
    logic [4:0]        status;
    logic [3:0][31:0]  resp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            arg_q  <= '0;
            tmo_q  <= TMO_W'(1024);
            div_q  <= DIV_W'(DIV_RESET);
            srst_q <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL: ctrl_q <= reg_wdata[13:0];
                RA_ARG:  arg_q  <= reg_wdata;
                RA_TMO:  tmo_q  <= reg_wdata[TMO_W-1:0];
                RA_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
                RA_SRST: srst_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    assign launch     = reg_we && (reg_addr == RA_ARG) && !srst_q;
    assign clr_status = reg_we && (reg_addr == RA_STAT);

    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {18'b0, ctrl_q};
            RA_ARG:  reg_rdata = arg_q;
            RA_TMO:  reg_rdata = 32'(tmo_q);
            RA_DIV:  reg_rdata = 32'(div_q);
            RA_SRST: reg_rdata = {31'b0, srst_q | eng_active};
            RA_STAT: reg_rdata = {27'b0, status};
            RA_RSP0: reg_rdata = resp[0];
            RA_RSP1: reg_rdata = resp[1];
            RA_RSP2: reg_rdata = resp[2];
            RA_RSP3: reg_rdata = resp[3];
            default: reg_rdata = '0;
        endcase
    end

    sdcmd_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .hold(srst_q), .div(div_q),
        .sd_clk(sd_clk), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    sdcmd_seq #(.TMO_W(TMO_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .srst(srst_q), .launch(launch),
        .cmd_index(ctrl_q[13:8]), .rsp_kind(ctrl_q[1:0]), .busy_req(ctrl_q[2]),
        .crc_req(ctrl_q[3]), .idx_req(ctrl_q[4]), .arg(reg_wdata), .tmo(tmo_q),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .cmd_in(cmd_in), .busy_in(busy_in),
        .clr_status(clr_status), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .status(status), .resp(resp), .active(eng_active)
    );

    // R1: the CMD value moves only on a falling SD clock
    a_r1_cmd_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_q && (cmd_out != $past(cmd_out))) |-> (!sd_clk && $past(sd_clk)));

endmodule

// File: tb/tb_sdcmd_engine.sv
`timescale 1ns/1ps
module tb_sdcmd_engine;

    localparam logic [3:0] A_CTRL = 4'd0, A_ARG = 4'd1, A_TMO = 4'd2, A_DIV = 4'd3;
    localparam logic [3:0] A_SRST = 4'd4, A_STAT = 4'd5;
    localparam logic [3:0] A_R0 = 4'd8, A_R1 = 4'd9, A_R2 = 4'd10, A_R3 = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sd_clk, cmd_out, cmd_oe;
    logic        cmd_in = 1'b1;
    logic        busy_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdcmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .busy_in(busy_in)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int n);
        logic [6:0] c;
        logic fb;
        c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [135:0] mk48(input logic [5:0] idx, input logic [31:0] pl, input logic [6:0] spoil);
        logic [39:0] h;
        h = {2'b00, idx, pl};
        return {88'b0, h, ref_crc({96'b0, h}, 40) ^ spoil, 1'b1};
    endfunction

    function automatic logic [135:0] mk136(input logic [119:0] body, input logic [6:0] spoil);
        return {2'b00, 6'h3F, body, ref_crc({16'b0, body}, 120) ^ spoil, 1'b1};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_status(output logic [31:0] s);
        s = '0;
        for (int i = 0; i < 4000 && s == 0; i++) rd(A_STAT, s);
    endtask

    // send a command, check the frame on the wire, act as the card
    task automatic run_cmd(input logic [5:0] idx, input logic [7:0] flags, input logic [31:0] arg,
                           input bit reply, input logic [135:0] rv, input int rn,
                           input bit poll, output logic [31:0] st);
        logic [47:0] got, exp;
        logic [39:0] h;
        wr(A_CTRL, {18'b0, idx, flags});
        wr(A_ARG, arg);
        @(posedge cmd_oe);
        for (int i = 47; i >= 0; i--) begin
            @(posedge sd_clk);
            got[i] = cmd_out;
        end
        h   = {2'b01, idx, arg};
        exp = {h, ref_crc({96'b0, h}, 40), 1'b1};
        chk("R1 frame", 64'(got), 64'(exp));
        if (reply) begin
            repeat (2) @(negedge sd_clk);
            for (int i = rn - 1; i >= 0; i--) begin
                @(negedge sd_clk);
                #1 cmd_in = rv[i];
            end
            @(negedge sd_clk);
            #1 cmd_in = 1'b1;
        end
        st = '0;
        if (poll) wait_status(st);
    endtask

    initial begin
        logic [31:0] s, w;
        logic [135:0] v;
        time t1, t2;
        int hits;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        rd(A_STAT, s);  chk("R10 reset status", 64'(s), 64'h0);
        rd(A_SRST, s);  chk("R11 reset srst readback", 64'(s), 64'h0);
        chk("R12 reset cmd_oe", 64'(cmd_oe), 64'h0);

        wr(A_DIV, 32'd1);
        repeat (3) @(posedge sd_clk);
        t1 = $time; @(posedge sd_clk); t2 = $time;
        chk("R2 period div1", 64'((t2 - t1) / 10), 64'd2);
        wr(A_DIV, 32'd4);
        repeat (3) @(posedge sd_clk);
        t1 = $time; @(posedge sd_clk); t2 = $time;
        chk("R2 period div4", 64'((t2 - t1) / 10), 64'd5);
        wr(A_DIV, 32'd0);
        repeat (3) @(posedge sd_clk);
        t1 = $time; @(posedge sd_clk); t2 = $time;
        chk("R2 period div0", 64'((t2 - t1) / 10), 64'd2);
        wr(A_DIV, 32'd1);
        wr(A_TMO, 32'd64);

        // R3 no response
        run_cmd(6'd0, 8'h00, 32'h0, 1'b0, '0, 0, 1'b1, s);
        chk("R3 no-response status", 64'(s), 64'h01);
        chk("R12 released after frame", 64'(cmd_oe), 64'h0);
        wr(A_STAT, 32'hFFFF);
        rd(A_STAT, s);  chk("R10 status cleared", 64'(s), 64'h0);

        // R4 clean 48-bit reply
        run_cmd(6'd17, 8'h19, 32'h0000_1000, 1'b1, mk48(6'd17, 32'h0000_0900, 7'h0), 48, 1'b1, s);
        chk("R4 status", 64'(s), 64'h01);
        rd(A_R0, w); chk("R4 word0", 64'(w), 64'h0000_0900);
        rd(A_R1, w); chk("R4 word1", 64'(w), 64'h0);
        rd(A_R3, w); chk("R4 word3", 64'(w), 64'h0);
        wr(A_STAT, 32'h0);

        // R5 bad CRC with and without checking
        run_cmd(6'd13, 8'h19, 32'h1234_0000, 1'b1, mk48(6'd13, 32'hCAFE_0001, 7'h05), 48, 1'b1, s);
        chk("R5 crc error", 64'(s), 64'h0A);
        wr(A_STAT, 32'h0);
        run_cmd(6'd13, 8'h11, 32'h1234_0000, 1'b1, mk48(6'd13, 32'hCAFE_0002, 7'h05), 48, 1'b1, s);
        chk("R5 crc ignored", 64'(s), 64'h01);
        rd(A_R0, w); chk("R5 payload kept", 64'(w), 64'hCAFE_0002);
        wr(A_STAT, 32'h0);

        // R6 index mismatch with and without checking
        run_cmd(6'd16, 8'h19, 32'd512, 1'b1, mk48(6'd18, 32'h0000_0900, 7'h0), 48, 1'b1, s);
        chk("R6 index error", 64'(s), 64'h12);
        wr(A_STAT, 32'h0);
        run_cmd(6'd16, 8'h09, 32'd512, 1'b1, mk48(6'd18, 32'h0000_0901, 7'h0), 48, 1'b1, s);
        chk("R6 index ignored", 64'(s), 64'h01);
        wr(A_STAT, 32'h0);

        // R7 136-bit reply
        v = mk136({32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 24'hC0FFEE}, 7'h0);
        run_cmd(6'd2, 8'h0A, 32'h0, 1'b1, v, 136, 1'b1, s);
        chk("R7 status", 64'(s), 64'h01);
        rd(A_R0, w); chk("R7 word0", 64'(w), 64'(v[127:96]));
        rd(A_R1, w); chk("R7 word1", 64'(w), 64'(v[95:64]));
        rd(A_R2, w); chk("R7 word2", 64'(w), 64'(v[63:32]));
        rd(A_R3, w); chk("R7 word3", 64'(w), 64'(v[31:0]));
        wr(A_STAT, 32'h0);
        v = mk136({32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 24'hC0FFEE}, 7'h40);
        run_cmd(6'd9, 8'h0A, 32'h0, 1'b1, v, 136, 1'b1, s);
        chk("R7 long crc error", 64'(s), 64'h0A);
        wr(A_STAT, 32'h0);

        // R8 timeout boundary
        wr(A_TMO, 32'd5);
        run_cmd(6'd8, 8'h19, 32'h1AA, 1'b0, '0, 0, 1'b0, s);
        @(negedge sd_clk);
        repeat (4) @(posedge sd_clk);
        rd(A_STAT, s);  chk("R8 not yet", 64'(s), 64'h0);
        @(posedge sd_clk);
        rd(A_STAT, s);  chk("R8 timeout", 64'(s), 64'h06);
        wr(A_STAT, 32'h0);
        wr(A_TMO, 32'd64);

        // R9 busy hold
        busy_in = 1'b1;
        run_cmd(6'd7, 8'h1D, 32'h1234_0000, 1'b1, mk48(6'd7, 32'h0000_0700, 7'h0), 48, 1'b0, s);
        repeat (30) @(negedge clk);
        rd(A_STAT, s);  chk("R9 held while busy", 64'(s), 64'h0);
        busy_in = 1'b0;
        wait_status(s);
        chk("R9 done after busy", 64'(s), 64'h01);
        wr(A_STAT, 32'h0);

        // R11 busy readback and soft reset
        wr(A_CTRL, 32'h0000_0000);
        wr(A_ARG, 32'h0);
        rd(A_SRST, s);  chk("R11 active readback", 64'(s), 64'h1);
        wait_status(s);
        rd(A_SRST, s);  chk("R11 idle readback", 64'(s), 64'h0);
        wr(A_STAT, 32'h0);
        wr(A_SRST, 32'h1);
        rd(A_SRST, s);  chk("R11 held readback", 64'(s), 64'h1);
        wr(A_ARG, 32'h55);
        hits = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cmd_oe) hits++;
        end
        chk("R11 launch blocked", 64'(hits), 64'h0);
        rd(A_STAT, s);  chk("R11 no status in reset", 64'(s), 64'h0);
        wr(A_SRST, 32'h0);
        rd(A_SRST, s);  chk("R11 released readback", 64'(s), 64'h0);
        run_cmd(6'd55, 8'h19, 32'h0, 1'b1, mk48(6'd55, 32'h0000_0120, 7'h0), 48, 1'b1, s);
        chk("R11 works after release", 64'(s), 64'h01);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule